// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus. It holds nine 4-bit configuration registers and lets an external master read and write them with 8-bit transfers. Both bus lines are brought into the system clock domain through synchronisers. Start and stop conditions are found by watching SDA change while SCL is high. The block only ever pulls SDA low. It never drives SCL and never starts a transfer.

Register 0x08 sets how the slave behaves on the bus. Its bit 3 picks the device-type nibble the slave answers to. Its bit 0 picks whether the three address bits in the frame must equal the strap pins. Its bits 2..1 pick the access mode: read/write, read-only or no access. Register 0x0C is a fault latch. A hardware input sets it, and a bus write can also load it. All register contents are brought out in parallel so that downstream logic can use them.

The controller is one state machine with these states:
- `ST_IDLE`: not addressed. Only a start condition moves it on, to `ST_ADDR`.
- `ST_ADDR`: shifts in the address byte. If the address matches, it goes to `ST_ADDR_ACK`. If not, it returns to `ST_IDLE`.
- `ST_ADDR_ACK`: drives the address ACK. It then goes to `ST_RDATA` for a read or `ST_PTR` for a write.
- `ST_PTR` then `ST_PTR_ACK`: receive the register pointer and acknowledge it.
- `ST_WDATA` then `ST_WDATA_ACK`: receive a data byte, store it, acknowledge it, then loop back to `ST_WDATA`.
- `ST_RDATA` then `ST_RDATA_ACK`: shift out a byte, then sample the master's ACK. An ACK returns to `ST_RDATA`. A NACK returns to `ST_IDLE`.

A stop condition in any state returns to `ST_IDLE`. A start condition in any state enters `ST_ADDR`.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave answers to device-type nibble 1011 when register 0x08 bit 3 is 0, and to 1010 when it is 1. After reset it answers 1011. Any other nibble gets no ACK.
- R2: When register 0x08 bit 0 is 1, frame address bits 3..1 must equal `strap_a[2:0]`. When it is 0, any value of those bits is accepted. After reset the bit is 1.
- R3: Register 0x08 bits 2..1 set the access mode: 00 is read/write, 01 is read-only, and 1x is no access. A write frame is NACKed at its address byte unless the mode is read/write, and it changes no register. A read frame is NACKed at its address byte in no-access mode.
- R4: A stop condition at any point ends the frame, releases SDA and discards any partial byte. A start condition at any point, including a repeated start, begins a new address byte.
- R5: A write frame is made of: an address byte with bit 0 = 0, then a pointer byte, then one or more data bytes. Each of these bytes is ACKed. The pointer is 8 bits wide and increments after each data byte.
- R6: A read frame (address bit 0 = 1) sends the byte at the current pointer MSB first, and the pointer then increments. The slave continues with the next byte on a master ACK, and releases SDA on a master NACK.
- R7: Each register stores data bits 3..0 only. Bits 7..4 are ignored on write and read back as zero.
- R8: The implemented addresses are 0x02 to 0x09 and 0x0C. Their reset values are 9, 2, B, C, C, 9, 1, 9 and 0. `cfg_flat` places the register at 0x02+k in bits [4k+3:4k] for k = 0..7, and register 0x0C in bits [35:32].
- R9: Any other address is ACKed, ignores writes and reads back 0x00.
- R10: A high `fault_set` sets bit 0 of register 0x0C on the next clock edge. This takes priority over a bus write in the same cycle. With `fault_set` low, a bus write loads the register normally.
- R11: The block only pulls SDA low (`sda_oe` = 1). `sda_oe` is low after reset, and it is asserted only in the cycle after a falling SCL edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| strap_a | input | 3 | Strap pins compared with address bits 3..1 |
| fault_set | input | 1 | Hardware fault; sets bit 0 of register 0x0C |
| cfg_flat | output | 36 | Parallel view of all register contents |

## Verification
The hardest cases to reach are the ones where the slave's own register 0x08 has changed how it treats the bus. For example, in read-only mode a write frame can no longer set the pointer, so a read must start from wherever the previous write frame left the pointer. The stimulus first writes 0x08 with a chosen value in read/write mode. This leaves the pointer at 0x09. The stimulus then probes refused writes, accepted reads across the unimplemented 0x0A, and the alternate address, with a reset between modes. A stop issued partway through a data byte, and a fault that is held high while the bus writes 0 to the latch, are driven as directed cases. Random write and read frames, some sent to a wrong strap address, run against a register model kept in the bench.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int REG_W      = 4;
    localparam int BYTE_W     = 8;
    localparam int NUM_SLOTS  = 9;
    localparam int CTRL_SLOT  = 6;   // register 0x08
    localparam int FAULT_SLOT = 8;   // register 0x0C
    localparam int CFG_W      = NUM_SLOTS * REG_W;
    localparam int CNT_W      = $clog2(BYTE_W) + 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } slv_state_t;

    typedef enum logic [1:0] {
        ACC_RW,
        ACC_RO,
        ACC_NONE
    } acc_mode_t;

    // Bus address of storage slot idx: slots 0..7 cover 0x02..0x09, slot 8 is 0x0C.
    function automatic logic [BYTE_W-1:0] slot_addr(input int idx);
        return (idx < 8) ? BYTE_W'(idx + 2) : 8'h0C;
    endfunction

    function automatic logic is_impl(input logic [BYTE_W-1:0] a);
        return ((a >= 8'h02) && (a <= 8'h09)) || (a == 8'h0C);
    endfunction

    function automatic logic [REG_W-1:0] slot_reset(input int idx);
        case (idx)
            0:       return 4'h9;
            1:       return 4'h2;
            2:       return 4'hB;
            3:       return 4'hC;
            4:       return 4'hC;
            5:       return 4'h9;
            6:       return 4'h1;
            7:       return 4'h9;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [CFG_W-1:0] cfg_reset_vec();
        logic [CFG_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            v[i*REG_W +: REG_W] = slot_reset(i);
        end
        return v;
    endfunction

    function automatic acc_mode_t decode_mode(input logic [1:0] f);
        if (f[1])      return ACC_NONE;
        else if (f[0]) return ACC_RO;
        else           return ACC_RW;
    endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_sync;
    logic [MSB:0] sda_sync;
    logic         scl_p;
    logic         sda_p;
    logic         scl_c;
    logic         sda_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[MSB-1:0], scl_i};
            sda_sync <= {sda_sync[MSB-1:0], sda_i};
            scl_p    <= scl_sync[MSB];
            sda_p    <= sda_sync[MSB];
        end
    end

    assign scl_c     = scl_sync[MSB];
    assign sda_c     = sda_sync[MSB];
    assign sda_s     = sda_c;
    assign scl_rise  = scl_c & ~scl_p;
    assign scl_fall  = ~scl_c & scl_p;
    // SDA edge while SCL stays high: falling is start, rising is stop
    assign start_det = scl_c & scl_p & sda_p & ~sda_c;
    assign stop_det  = scl_c & scl_p & ~sda_p & sda_c;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import i2c_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_nib,
    input  logic [BYTE_W-1:0] rd_addr,
    input  logic              fault_set,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [REG_W-1:0]  ctrl_nib
);

    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] cfg_d;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [BYTE_W-1:0] SLOT_ADDR = slot_addr(g);
        logic hit;
        assign hit = wr_en && (wr_addr == SLOT_ADDR);
        if (g == FAULT_SLOT) begin : g_fault
            // hardware fault wins over a same-cycle bus write on bit 0
            assign cfg_d[g*REG_W +: REG_W] =
                {hit ? wr_nib[REG_W-1:1] : cfg_q[g*REG_W+1 +: REG_W-1],
                 fault_set | (hit ? wr_nib[0] : cfg_q[g*REG_W])};
        end else begin : g_plain
            assign cfg_d[g*REG_W +: REG_W] = hit ? wr_nib : cfg_q[g*REG_W +: REG_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= cfg_reset_vec();
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_addr == slot_addr(i)) rd_data[REG_W-1:0] = cfg_q[i*REG_W +: REG_W];
        end
    end

    assign cfg_o    = cfg_q;
    assign ctrl_nib = cfg_q[CTRL_SLOT*REG_W +: REG_W];

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [2:0]       strap_a,
    input  logic             fault_set,
    output logic [CFG_W-1:0] cfg_flat
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rd_data;
    logic [REG_W-1:0]  ctrl_nib;
    logic              wr_en;

    slv_state_t        state_q, state_d;
    logic [BYTE_W-1:0] sh_q, sh_d;
    logic [BYTE_W-1:0] ptr_q, ptr_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              rw_q, rw_d;
    logic              oe_q, oe_d;

    logic [3:0]        dev_type;
    logic              strap_en;
    acc_mode_t         mode;
    logic              addr_ok;

    i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (ptr_q),
        .wr_nib    (sh_q[REG_W-1:0]),
        .rd_addr   (ptr_q),
        .fault_set (fault_set),
        .rd_data   (rd_data),
        .cfg_o     (cfg_flat),
        .ctrl_nib  (ctrl_nib)
    );

    // bus personality taken from register 0x08
    assign dev_type = ctrl_nib[3] ? 4'b1010 : 4'b1011;
    assign strap_en = ctrl_nib[0];
    assign mode     = decode_mode(ctrl_nib[2:1]);
    assign addr_ok  = (sh_q[7:4] == dev_type)
                   && (!strap_en || (sh_q[3:1] == strap_a))
                   && (sh_q[0] ? (mode != ACC_NONE) : (mode == ACC_RW));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            ptr_q <= '0;
            cnt_q <= '0;
            rw_q  <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            sh_q  <= sh_d;
            ptr_q <= ptr_d;
            cnt_q <= cnt_d;
            rw_q  <= rw_d;
            oe_q  <= oe_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        ptr_d   = ptr_q;
        cnt_d   = cnt_q;
        rw_d    = rw_q;
        oe_d    = oe_q;
        wr_en   = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else if (start_det) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
            oe_d    = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise && cnt_q < LAST_BIT) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LAST_BIT) begin
                        cnt_d = '0;
                        if (addr_ok) begin
                            state_d = ST_ADDR_ACK;
                            rw_d    = sh_q[0];
                            oe_d    = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rw_q) begin
                            state_d = ST_RDATA;
                            sh_d    = rd_data;
                            oe_d    = ~rd_data[BYTE_W-1];
                        end else begin
                            state_d = ST_PTR;
                            oe_d    = 1'b0;
                        end
                    end
                end
                ST_PTR: begin
                    if (scl_rise && cnt_q < LAST_BIT) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LAST_BIT) begin
                        cnt_d   = '0;
                        ptr_d   = sh_q;
                        state_d = ST_PTR_ACK;
                        oe_d    = 1'b1;
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_WDATA;
                        cnt_d   = '0;
                        oe_d    = 1'b0;
                    end
                end
                ST_WDATA: begin
                    if (scl_rise && cnt_q < LAST_BIT) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LAST_BIT) begin
                        cnt_d   = '0;
                        wr_en   = 1'b1;
                        ptr_d   = ptr_q + 1'b1;
                        state_d = ST_WDATA_ACK;
                        oe_d    = 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt_q == LAST_TX) begin
                            cnt_d   = '0;
                            oe_d    = 1'b0;
                            ptr_d   = ptr_q + 1'b1;
                            state_d = ST_RDATA_ACK;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                            sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
                            oe_d  = ~sh_q[BYTE_W-2];
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        sh_d = {{(BYTE_W-1){1'b0}}, sda_s};
                    end else if (scl_fall) begin
                        if (!sh_q[0]) begin
                            state_d = ST_RDATA;
                            cnt_d   = '0;
                            sh_d    = rd_data;
                            oe_d    = ~rd_data[BYTE_W-1];
                        end else begin
                            state_d = ST_IDLE;
                            oe_d    = 1'b0;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign sda_oe = oe_q;

endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
    import i2c_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_fall,
    input logic              stop_det,
    input logic              fault_set,
    input logic [CFG_W-1:0]  cfg_flat,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_addr
);

    // R4: a stop releases the data line on the next edge
    p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe)
        else $error("p_stop_release_r4");

    // R11: the pull-down only starts right after a detected SCL fall
    p_oe_rise_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall))
        else $error("p_oe_rise_on_fall_r11");

    // R10: fault input sets bit 0 of register 0x0C
    p_fault_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set |=> cfg_flat[FAULT_SLOT*REG_W])
        else $error("p_fault_sets_r10");

    // R9: a store to an unimplemented address leaves every register alone
    p_unimpl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_impl(wr_addr) && !fault_set) |=> $stable(cfg_flat))
        else $error("p_unimpl_write_r9");

endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .stop_det  (stop_det),
    .fault_set (fault_set),
    .cfg_flat  (cfg_flat),
    .wr_en     (wr_en),
    .wr_addr   (ptr_q)
);

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 5;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] A_DEF = {4'b1011, STRAP};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda_low = 1'b0;
    logic        fault_set = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic [35:0] cfg_flat;

    int n_chk = 0;
    int n_err = 0;
    logic [3:0] mdl [16];
    logic [7:0] wbuf [4];
    logic [7:0] rbuf [16];

    assign sda_line = ~(m_sda_low | sda_oe);

    i2c_cfg_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_a   (STRAP),
        .fault_set (fault_set),
        .cfg_flat  (cfg_flat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic tb_impl(input logic [7:0] a);
        return (a >= 8'd2 && a <= 8'd9) || a == 8'd12;
    endfunction

    function automatic logic [3:0] exp_reg(input logic [7:0] a);
        if (a < 8'd16 && tb_impl(a)) return mdl[a[3:0]];
        return 4'h0;
    endfunction

    function automatic logic [35:0] exp_vec();
        logic [35:0] v;
        for (int k = 0; k < 8; k++) v[k*4 +: 4] = mdl[k+2];
        v[35:32] = mdl[12];
        return v;
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 16; a++) mdl[a] = 4'h0;
        mdl[2] = 4'h9; mdl[3] = 4'h2; mdl[4] = 4'hB; mdl[5] = 4'hC;
        mdl[6] = 4'hC; mdl[7] = 4'h9; mdl[8] = 4'h1; mdl[9] = 4'h9;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; m_scl = 1'b1; m_sda_low = 1'b0; fault_set = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        repeat (4) @(negedge clk);
    endtask

    task automatic tick();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; tick();
        m_scl = 1'b1; tick();
        m_sda_low = 1'b1; tick();
        m_scl = 1'b0; tick();
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; tick();
        m_scl = 1'b1; tick();
        m_sda_low = 1'b0; tick();
    endtask

    task automatic m_bit(input logic b);
        m_sda_low = ~b; tick();
        m_scl = 1'b1; tick(); tick();
        m_scl = 1'b0; tick();
    endtask

    task automatic m_rbit(output logic b);
        m_sda_low = 1'b0; tick();
        m_scl = 1'b1; tick();
        b = sda_line; tick();
        m_scl = 1'b0; tick();
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit(d[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(output logic [7:0] d, input logic last);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            d[i] = b;
        end
        m_bit(last);
    endtask

    // write n bytes from wbuf starting at ptr; model follows when expected to be accepted
    task automatic wr_frame(input logic [6:0] a7, input logic [7:0] ptr, input int n,
                            input logic exp_ack, input string tag);
        logic ack;
        m_start();
        m_wbyte({a7, 1'b0}, ack);
        check({tag, " addr ack"}, 64'(ack), 64'(exp_ack));
        if (ack) begin
            m_wbyte(ptr, ack);
            check("R5 pointer ack", 64'(ack), 64'd1);
            for (int i = 0; i < n; i++) begin
                logic [7:0] a;
                a = ptr + 8'(i);
                m_wbyte(wbuf[i], ack);
                check("R5 data ack", 64'(ack), 64'd1);
                if (a < 8'd16 && tb_impl(a))
                    mdl[a[3:0]] = wbuf[i][3:0] | ((a == 8'd12) ? {3'b000, fault_set} : 4'h0);
            end
        end
        m_stop();
    endtask

    // read n bytes from ptr (optionally setting the pointer first) and compare with model
    task automatic rd_frame(input logic [6:0] a7, input logic [7:0] ptr, input logic set_ptr,
                            input int n, input logic exp_ack, input string tag);
        logic ack;
        m_start();
        if (set_ptr) begin
            m_wbyte({a7, 1'b0}, ack);
            m_wbyte(ptr, ack);
            m_start();
        end
        m_wbyte({a7, 1'b1}, ack);
        check({tag, " read addr ack"}, 64'(ack), 64'(exp_ack));
        if (ack) begin
            for (int i = 0; i < n; i++) begin
                m_rbyte(rbuf[i], i == n - 1);
                check({tag, " read data"}, 64'(rbuf[i]), 64'({4'h0, exp_reg(ptr + 8'(i))}));
            end
            check("R6 released after NACK", 64'(sda_oe), 64'd0);
        end
        m_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic ack;
        void'($urandom(32'd4711));
        do_reset();

        // R8 / R11: reset state
        check("R11 sda_oe after reset", 64'(sda_oe), 64'd0);
        check("R8 reset contents", 64'(cfg_flat), 64'h0919CCB29);

        // R8 / R9 / R6: read the whole low space in one burst
        rd_frame(A_DEF, 8'h00, 1'b1, 13, 1'b1, "R8 R9 R6 burst");

        // R1 / R2: wrong device type and wrong strap refused
        m_start(); m_wbyte({4'b1010, STRAP, 1'b1}, ack); m_stop();
        check("R1 1010 refused at reset", 64'(ack), 64'd0);
        m_start(); m_wbyte({4'b1011, 3'b010, 1'b1}, ack); m_stop();
        check("R2 strap mismatch refused", 64'(ack), 64'd0);

        // R7: upper nibble ignored
        wbuf[0] = 8'hF5;
        wr_frame(A_DEF, 8'h02, 1, 1'b1, "R7 write");
        check("R7 stored nibble", 64'(cfg_flat[3:0]), 64'h5);
        rd_frame(A_DEF, 8'h02, 1'b1, 1, 1'b1, "R7 readback");

        // R5 / R9: burst write across unimplemented 0x0A, 0x0B into 0x0C
        wbuf[0] = 8'h37; wbuf[1] = 8'hAA; wbuf[2] = 8'h55; wbuf[3] = 8'h06;
        wr_frame(A_DEF, 8'h09, 4, 1'b1, "R5 burst");
        check("R5 R9 burst contents", 64'(cfg_flat), 64'(exp_vec()));
        rd_frame(A_DEF, 8'h09, 1'b1, 4, 1'b1, "R9 burst readback");

        // R10: fault pulse, fault priority over a bus write, then clear
        @(negedge clk); fault_set = 1'b1;
        @(negedge clk); fault_set = 1'b0;
        mdl[12][0] = 1'b1;
        check("R10 fault pulse sets latch", 64'(cfg_flat[32]), 64'd1);
        fault_set = 1'b1;
        wbuf[0] = 8'h0E;
        wr_frame(A_DEF, 8'h0C, 1, 1'b1, "R10 write under fault");
        check("R10 fault wins", 64'(cfg_flat[35:32]), 64'hF);
        fault_set = 1'b0;
        wbuf[0] = 8'h00;
        wr_frame(A_DEF, 8'h0C, 1, 1'b1, "R10 clear");
        rd_frame(A_DEF, 8'h0C, 1'b1, 1, 1'b1, "R10 cleared readback");

        // R4: stop in the middle of a data byte discards it
        m_start(); m_wbyte({A_DEF, 1'b0}, ack); m_wbyte(8'h02, ack);
        m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b0);
        m_stop();
        check("R4 partial byte discarded", 64'(cfg_flat), 64'(exp_vec()));
        check("R4 released after stop", 64'(sda_oe), 64'd0);
        rd_frame(A_DEF, 8'h02, 1'b1, 1, 1'b1, "R4 next frame");

        // R5 / R6 random frames, some at a wrong strap address
        for (int it = 0; it < 30; it++) begin
            logic [7:0] p;
            int         n;
            logic       bad;
            p   = 8'($urandom_range(0, 13));
            n   = $urandom_range(1, 3);
            bad = ($urandom_range(0, 4) == 0);
            for (int k = 0; k < n; k++) begin
                wbuf[k] = 8'($urandom);
                if (p + 8'(k) == 8'd8) wbuf[k][3:0] = 4'h1;
            end
            wr_frame(bad ? {4'b1011, STRAP ^ 3'b011} : A_DEF, p, n, !bad, "R2 R5 random write");
            check("R8 random contents", 64'(cfg_flat), 64'(exp_vec()));
            rd_frame(A_DEF, 8'($urandom_range(0, 13)), 1'b1, $urandom_range(1, 3), 1'b1, "R6 random read");
        end

        // R1 / R2: switch to 1010 with strap compare off
        do_reset();
        wbuf[0] = 8'h08;
        wr_frame(A_DEF, 8'h08, 1, 1'b1, "R1 cfg write");
        m_start(); m_wbyte({A_DEF, 1'b1}, ack); m_stop();
        check("R1 1011 refused after switch", 64'(ack), 64'd0);
        rd_frame({4'b1010, 3'b010}, 8'h09, 1'b0, 1, 1'b1, "R1 R2 alt address any strap");

        // R3: read-only mode
        do_reset();
        wbuf[0] = 8'h03;
        wr_frame(A_DEF, 8'h08, 1, 1'b1, "R3 cfg ro");
        wbuf[0] = 8'h00;
        wr_frame(A_DEF, 8'h02, 1, 1'b0, "R3 ro write refused");
        check("R3 ro write no effect", 64'(cfg_flat), 64'(exp_vec()));
        rd_frame(A_DEF, 8'h09, 1'b0, 2, 1'b1, "R3 R9 ro read");

        // R3: no-access mode
        do_reset();
        wbuf[0] = 8'h05;
        wr_frame(A_DEF, 8'h08, 1, 1'b1, "R3 cfg none");
        wbuf[0] = 8'h00;
        wr_frame(A_DEF, 8'h02, 1, 1'b0, "R3 none write refused");
        rd_frame(A_DEF, 8'h09, 1'b0, 1, 1'b0, "R3 none read refused");
        check("R3 none contents", 64'(cfg_flat), 64'(exp_vec()));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule